// File: doc/BRIEF.md
# Power-Mode and Wake-Up Controller

This block sits beside a small 8-bit processor core and decides which internal clock domains receive clock edges. In normal run mode the core and its peripherals are both clocked. A software write to the power control register can select a light sleep or a deep sleep. In light sleep the core clock is gated and the timers, serial ports and interrupt logic keep running. In deep sleep the oscillator is stopped and the external bus strobes are held low. The controller also qualifies the external reset pin, accepts a reset from a timer overflow, and gates the clocks for a fixed stabilisation interval after an interrupt wakes the device from deep sleep.

The block runs from a free-running clock that stands in for the oscillator. It drives clock-enable levels for the core and peripheral domains, an oscillator run enable, an internal reset, and two force-low levels for the address-latch and program-strobe pins. The power control register holds four bits: bit 0 requests light sleep, bit 1 requests deep sleep, and bits 2 and 3 are general-purpose flags that software can use to record why it went to sleep.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, the controller is in run mode. Outputs {cpu_clk_en, per_clk_en, osc_run, ale_low, psen_low} read 5'b11100, `ctl_rdata` reads 0 and `core_rst` reads 0.
- R2: In run mode, a write with bit 0 set and bit 1 clear enters light sleep at the next clock edge. The outputs then read 5'b01100 and `ctl_rdata` bit 0 reads 1.
- R3: In run mode, a write with bit 1 set enters deep sleep at the next clock edge, whatever bit 0 holds. The outputs read 5'b00011, and `ctl_rdata` shows bit 1 set and bit 0 clear.
- R4: In light sleep, any set bit of `irq_pend` returns the controller to run mode at the next edge and clears bit 0. Flag bits 2 and 3 keep their written values.
- R5: `core_rst` asserts at the edge that samples `rst_pin` high for the 24th consecutive time, and it stays high while the pin stays high. A shorter high pulse has no effect. A qualified reset clears all four control bits and returns the controller to run mode.
- R6: A one-cycle `tmr_ovf_rst` pulse raises `core_rst` for one cycle at the next edge, clears all control bits and ends light sleep.
- R7: In deep sleep only `xwake` wakes the device. `irq_pend` and control-register writes have no effect.
- R8: After an `xwake` wake-up, the outputs read 5'b00111 for 1536 clock periods counted from the wake edge. The controller then enters run mode and clears bit 1. Every new deep-sleep entry restarts the count from zero.
- R9: A qualified reset in deep sleep returns the controller to run mode at the qualifying edge, without the stabilisation wait.
- R10: Control-register writes made in light sleep have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ctl_we | input | 1 | Power control register write strobe |
| ctl_wdata | input | 4 | Write data: bit0 light sleep, bit1 deep sleep, bits 3:2 flags |
| ctl_rdata | output | 4 | Current power control register contents |
| irq_pend | input | N_IRQ | Enabled pending interrupt requests |
| xwake | input | N_XWAKE | Enabled external interrupts allowed to wake from deep sleep |
| rst_pin | input | 1 | External reset pin, active high |
| tmr_ovf_rst | input | 1 | Reset pulse from timer overflow |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Internal reset to the core and registers |
| ale_low | output | 1 | Force address-latch pin low |
| psen_low | output | 1 | Force program-strobe pin low |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that `xwake` and `irq_pend` already carry their enable masks, so any set bit is a valid request. The bench changes inputs only on the falling edge and holds `ctl_we` for exactly one cycle. It raises `xwake` and `irq_pend` only in the mode under test, except for the deliberate deep-sleep check in which `irq_pend` must be ignored. The random phase draws write values, interrupt bits and reset-pin pulse lengths on both sides of 24 cycles. Each random case starts from run mode.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2,
    MODE_WAKE = 2'd3
  } pmode_e;

  typedef struct packed {
    logic gf1;
    logic gf0;
    logic pd;
    logic idl;
  } pctl_t;

  localparam int CTL_W = 4;
endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic req
);
  localparam int QW = $clog2(HOLD + 1);
  localparam logic [QW-1:0] FULL = QW'(HOLD);
  localparam logic [QW-1:0] LAST = QW'(HOLD - 1);

  logic [QW-1:0] cnt_q;

  // consecutive-high counter, saturating at HOLD
  always_ff @(posedge clk) begin
    if (rst || !pin) cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  assign req = pin && (cnt_q >= LAST);

  generate
    if (HOLD > 1) begin : g_chk
      p_pin_held_r5: assert property (@(posedge clk) disable iff (rst)
        req |-> (pin && $past(pin)));
    end
  endgenerate
endmodule

// File: rtl/wake_timer.sv
module wake_timer #(
  parameter int DLY = 1536
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(DLY);
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (run) cnt_q <= done ? '0 : cnt_q + 1'b1;
  end

  p_done_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (run && !clr));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int RST_HOLD = 24,
  parameter int WAKE_DLY = 1536,
  parameter int N_IRQ    = 8,
  parameter int N_XWAKE  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctl_we,
  input  logic [3:0]         ctl_wdata,
  output logic [3:0]         ctl_rdata,
  input  logic [N_IRQ-1:0]   irq_pend,
  input  logic [N_XWAKE-1:0] xwake,
  input  logic               rst_pin,
  input  logic               tmr_ovf_rst,
  output logic               cpu_clk_en,
  output logic               per_clk_en,
  output logic               osc_run,
  output logic               core_rst,
  output logic               ale_low,
  output logic               psen_low
);
  pmode_e st_q, st_d;
  pctl_t  ctl_q, ctl_d;
  logic   pin_req, rrq;
  logic   wake_clr, wake_run, wake_done;

  rst_qualifier #(.HOLD(RST_HOLD)) u_rq (
    .clk(clk), .rst(rst), .pin(rst_pin), .req(pin_req)
  );

  wake_timer #(.DLY(WAKE_DLY)) u_wt (
    .clk(clk), .rst(rst), .clr(wake_clr), .run(wake_run), .done(wake_done)
  );

  assign rrq = pin_req || tmr_ovf_rst;

  always_comb begin
    st_d     = st_q;
    ctl_d    = ctl_q;
    wake_clr = 1'b0;
    wake_run = 1'b0;
    if (rrq) begin
      st_d     = MODE_RUN;
      ctl_d    = '0;
      wake_clr = 1'b1;
    end else begin
      unique case (st_q)
        MODE_RUN: begin
          if (ctl_we) begin
            ctl_d.gf1 = ctl_wdata[3];
            ctl_d.gf0 = ctl_wdata[2];
            if (ctl_wdata[1]) begin
              ctl_d.pd  = 1'b1;
              ctl_d.idl = 1'b0;
              st_d      = MODE_PD;
              wake_clr  = 1'b1;
            end else if (ctl_wdata[0]) begin
              ctl_d.idl = 1'b1;
              st_d      = MODE_IDLE;
            end
          end
        end
        MODE_IDLE: begin
          if (|irq_pend) begin
            ctl_d.idl = 1'b0;
            st_d      = MODE_RUN;
          end
        end
        MODE_PD: begin
          if (|xwake) st_d = MODE_WAKE;
        end
        MODE_WAKE: begin
          wake_run = 1'b1;
          if (wake_done) begin
            ctl_d.pd = 1'b0;
            st_d     = MODE_RUN;
          end
        end
        default: st_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= MODE_RUN;
      ctl_q      <= '0;
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_run    <= 1'b1;
      core_rst   <= 1'b0;
      ale_low    <= 1'b0;
      psen_low   <= 1'b0;
    end else begin
      st_q       <= st_d;
      ctl_q      <= ctl_d;
      cpu_clk_en <= (st_d == MODE_RUN);
      per_clk_en <= (st_d == MODE_RUN) || (st_d == MODE_IDLE);
      osc_run    <= (st_d != MODE_PD);
      core_rst   <= rrq;
      ale_low    <= (st_d == MODE_PD) || (st_d == MODE_WAKE);
      psen_low   <= (st_d == MODE_PD) || (st_d == MODE_WAKE);
    end
  end

  assign ctl_rdata = ctl_q;

  p_idle_clocks_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == MODE_IDLE) |-> (per_clk_en && !cpu_clk_en && osc_run));

  p_pd_outputs_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == MODE_PD) |-> (!osc_run && ale_low && psen_low && !cpu_clk_en && !per_clk_en));

  p_pd_priority_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == MODE_RUN && ctl_we && ctl_wdata[1] && !rrq) |=> (st_q == MODE_PD && !ctl_q.idl));

  p_core_rst_clears_r5: assert property (@(posedge clk) disable iff (rst)
    core_rst |-> (st_q == MODE_RUN && ctl_q == '0));

  p_pd_wake_src_r7: assert property (@(posedge clk) disable iff (rst)
    (st_q == MODE_WAKE && $past(st_q) == MODE_PD) |-> $past(|xwake));

  p_wake_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == MODE_RUN && $past(st_q) == MODE_WAKE) |-> $past(wake_done || rrq));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       ctl_we;
  logic [3:0] ctl_wdata;
  logic [3:0] ctl_rdata;
  logic [7:0] irq_pend;
  logic [7:0] xwake;
  logic       rst_pin;
  logic       tmr_ovf_rst;
  logic       cpu_clk_en, per_clk_en, osc_run, core_rst, ale_low, psen_low;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  localparam logic [4:0] O_RUN  = 5'b11100;
  localparam logic [4:0] O_IDLE = 5'b01100;
  localparam logic [4:0] O_PD   = 5'b00011;
  localparam logic [4:0] O_WAKE = 5'b00111;

  always #2 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .irq_pend(irq_pend), .xwake(xwake),
    .rst_pin(rst_pin), .tmr_ovf_rst(tmr_ovf_rst), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_run(osc_run), .core_rst(core_rst),
    .ale_low(ale_low), .psen_low(psen_low)
  );

  function automatic logic [4:0] outs();
    return {cpu_clk_en, per_clk_en, osc_run, ale_low, psen_low};
  endfunction

  function automatic logic [4:0] exp_after_write(input logic [3:0] w);
    if (w[1]) return O_PD;
    if (w[0]) return O_IDLE;
    return O_RUN;
  endfunction

  function automatic logic [3:0] exp_ctl(input logic [3:0] w);
    return {w[3], w[2], w[1], w[1] ? 1'b0 : w[0]};
  endfunction

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w);
    ctl_we = 1'b1; ctl_wdata = w;
    step(1);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic pin_reset();
    rst_pin = 1'b1; step(24);
    rst_pin = 1'b0; step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; irq_pend = '0; xwake = '0;
    rst_pin = 1'b0; tmr_ovf_rst = 1'b0;
    step(3);
    rst = 1'b0;
    step(1);

    chk("R1 outputs", outs(), O_RUN);
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 core_rst", core_rst, 0);

    wr(4'b0101);
    chk("R2 outputs", outs(), O_IDLE);
    chk("R2 ctl", ctl_rdata, 5);

    wr(4'b0010);
    chk("R10 outputs", outs(), O_IDLE);
    chk("R10 ctl", ctl_rdata, 5);

    irq_pend = 8'h10; step(1); irq_pend = '0;
    chk("R4 outputs", outs(), O_RUN);
    chk("R4 ctl flags kept", ctl_rdata, 4);

    wr(4'b0011);
    chk("R3 outputs", outs(), O_PD);
    chk("R3 ctl pd wins", ctl_rdata, 2);

    irq_pend = 8'hFF; step(5); irq_pend = '0;
    chk("R7 irq ignored", outs(), O_PD);
    wr(4'b0001);
    chk("R7 write ignored", ctl_rdata, 2);

    xwake = 8'h01; step(1); xwake = '0;
    chk("R8 wake gated", outs(), O_WAKE);
    step(1535);
    chk("R8 still gated", outs(), O_WAKE);
    step(1);
    chk("R8 run after 1536", outs(), O_RUN);
    chk("R8 pd cleared", ctl_rdata, 0);

    wr(4'b1101);
    rst_pin = 1'b1; step(23); rst_pin = 1'b0;
    chk("R5 short pulse core_rst", core_rst, 0);
    step(2);
    chk("R5 short pulse mode", outs(), O_IDLE);
    chk("R5 short pulse ctl", ctl_rdata, 13);
    rst_pin = 1'b1; step(23);
    chk("R5 before 24", core_rst, 0);
    step(1);
    chk("R5 at 24", core_rst, 1);
    chk("R5 mode run", outs(), O_RUN);
    chk("R5 ctl cleared", ctl_rdata, 0);
    step(3);
    chk("R5 held high", core_rst, 1);
    rst_pin = 1'b0; step(1);
    chk("R5 release", core_rst, 0);

    wr(4'b0010);
    rst_pin = 1'b1; step(24);
    chk("R9 core_rst", core_rst, 1);
    chk("R9 run without wait", outs(), O_RUN);
    rst_pin = 1'b0; step(1);

    wr(4'b1001);
    tmr_ovf_rst = 1'b1; step(1); tmr_ovf_rst = 1'b0;
    chk("R6 core_rst", core_rst, 1);
    chk("R6 mode run", outs(), O_RUN);
    chk("R6 ctl cleared", ctl_rdata, 0);
    step(1);
    chk("R6 one cycle", core_rst, 0);

    wr(4'b0010);
    xwake = 8'h80; step(1); xwake = '0;
    step(700);
    chk("R8 partial wake", outs(), O_WAKE);
    pin_reset();
    wr(4'b0010);
    xwake = 8'h04; step(1); xwake = '0;
    step(1535);
    chk("R8 count restarted", outs(), O_WAKE);
    step(1);
    chk("R8 second wake", outs(), O_RUN);

    void'($urandom(32'd1234));
    for (int i = 0; i < 150; i++) begin
      logic [3:0] w;
      w = 4'($urandom % 16);
      wr(w);
      chk("R2/R3 random mode", outs(), exp_after_write(w));
      chk("R2/R3 random ctl", ctl_rdata, exp_ctl(w));
      if (!w[1] && w[0]) begin
        irq_pend = 8'(1 << ($urandom % 8)); step(1); irq_pend = '0;
        chk("R4 random wake", outs(), O_RUN);
        chk("R4 random flags", ctl_rdata, {w[3], w[2], 2'b00});
      end else if (w[1]) begin
        int len;
        len = 1 + int'($urandom % 30);
        rst_pin = 1'b1; step(len);
        if (len >= 24) begin
          chk("R9 random reset", outs(), O_RUN);
          chk("R5 random core_rst", core_rst, 1);
        end else begin
          chk("R5 random short", outs(), O_PD);
          chk("R5 random no rst", core_rst, 0);
        end
        rst_pin = 1'b0; step(1);
        if (len < 24) pin_reset();
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule